// File: doc/BRIEF.md
# Asymmetric Carrier-Compare PWM Gate Generator

This block turns three per-phase firing-time words into six inverter gate drives. One up-down counter forms a centre-symmetric triangular carrier that rises from zero to a peak and falls back, one step per clock. Each phase keeps its own copy of the firing time and compares it with the carrier. The phase demand is high whenever the carrier has reached the firing time.

The firing-time copies are refreshed at both ends of the carrier: at the valley and at the peak. The rising and falling halves of one switching period can therefore use different values, which gives pulses that are asymmetric about the carrier peak. This lets an upstream controller update its output twice per switching period. A one-clock sample strobe marks each turning point so that the controller can align its own sampling to it.

Each phase demand is split into a complementary high-side and low-side gate pair. A fixed dead interval is inserted before either gate of the pair turns on.

Top module: `pwm_gate_gen`

## Requirements
- R1: The carrier starts at 0 after reset and counts up. It changes by exactly one every clock, turns at CARRIER_PEAK (default 2000) and at 0, and so has a period of 2·CARRIER_PEAK clocks (4000).
- R2: `sample_stb` is high for exactly one clock in every cycle in which the carrier sits at 0 or at CARRIER_PEAK, and is low otherwise. The first strobe after reset is at the peak, in the CARRIER_PEAK-th cycle after reset is released.
- R3: Each phase captures its firing-time input only on the clock edge at which the carrier enters a turning point. The captured value governs the whole half period that follows: the value captured at the valley governs the rising half, and the value captured at the peak governs the falling half. Input changes at any other time have no effect on the gates.
- R4: For a firing time f with 0 < f < CARRIER_PEAK, the phase demand is high in every cycle whose carrier value is at least f. With valley value a and peak value b, the high-side gate is on for 2·CARRIER_PEAK+1−a−b−DEAD_CLKS clocks per period.
- R5: A firing time of CARRIER_PEAK or more holds the phase demand low for that whole half period. A firing time of 0 holds it high for that whole half period.
- R6: On every change of phase demand, both gates of that phase are low for exactly DEAD_CLKS clocks (default 100). The gate that matches the new demand then turns on.
- R7: The high-side and low-side gates of a phase are never high in the same cycle.
- R8: A demand run of DEAD_CLKS clocks or fewer turns neither gate on. A run of L > DEAD_CLKS clocks gives a single pulse of L−DEAD_CLKS clocks on the matching gate.
- R9: The reset is synchronous and active high. During reset all gates and the strobe are low, and the firing-time copies hold CARRIER_PEAK (demand low). After reset is released, the low-side gates turn on after DEAD_CLKS clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one carrier step per cycle |
| rst | input | 1 | Synchronous active-high reset |
| ft_u | input | FT_W | Firing time, phase U |
| ft_v | input | FT_W | Firing time, phase V |
| ft_w | input | FT_W | Firing time, phase W |
| gate_hi | output | 3 | High-side gates, bit 0 = U, 1 = V, 2 = W |
| gate_lo | output | 3 | Low-side gates, same bit order |
| sample_stb | output | 1 | One-clock strobe at each carrier turning point |

## Verification
The assertions assume only that reset is held for at least one clock edge before it is released. They place no constraint on the firing-time inputs, because those inputs are sampled only at turning points and any value, including out-of-range ones, must leave the gates well formed. The stimulus changes firing times only on falling clock edges. It deliberately disturbs the inputs in the middle of a half period and drives values beyond the peak to show they are ignored or clamped. Each measured period is preceded by a warm-up period with the same values, so that the count windows start from a settled gate state.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;
  localparam int NUM_PHASES = 3;
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} car_dir_e;
endpackage

// File: rtl/pwm_carrier.sv
module pwm_carrier
  import pwm_gate_pkg::*;
#(
  parameter int PEAK = 2000,
  parameter int CW   = $clog2(PEAK + 1)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] cnt_o,
  output logic          load_o,
  output logic          stb_o
);
  car_dir_e      dir_q, dir_n;
  logic [CW-1:0] nxt;

  // Next carrier value; a turning point is announced one edge ahead as load_o.
  always_comb begin
    nxt   = (dir_q == DIR_UP) ? cnt_o + CW'(1) : cnt_o - CW'(1);
    dir_n = dir_q;
    if (nxt == CW'(PEAK))  dir_n = DIR_DOWN;
    else if (nxt == '0)    dir_n = DIR_UP;
    load_o = (nxt == CW'(PEAK)) || (nxt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
      dir_q <= DIR_UP;
      stb_o <= 1'b0;
    end else begin
      cnt_o <= nxt;
      dir_q <= dir_n;
      stb_o <= load_o;
    end
  end

  // R1: carrier stays within range and moves by one each clock
  p_carrier_range_r1: assert property (@(posedge clk) disable iff (rst)
    cnt_o <= CW'(PEAK));
  p_carrier_step_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((cnt_o == $past(cnt_o) + CW'(1)) || (cnt_o == $past(cnt_o) - CW'(1))));
  // R2: strobe is a single clock and only at a turning point
  p_strobe_turn_r2: assert property (@(posedge clk) disable iff (rst)
    stb_o |-> (cnt_o == '0 || cnt_o == CW'(PEAK)));
  p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
    stb_o |=> !stb_o);
endmodule

// File: rtl/pwm_phase_cmp.sv
module pwm_phase_cmp #(
  parameter int PEAK = 2000,
  parameter int CW   = 11,
  parameter int FW   = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [FW-1:0] ft_i,
  output logic          raw_o
);
  logic [FW-1:0] act_q;

  // Shadow copy refreshed only at carrier turning points.
  always_ff @(posedge clk) begin
    if (rst)         act_q <= FW'(PEAK);
    else if (load_i) act_q <= ft_i;
  end

  // Values at or beyond the peak clamp the demand low for the half period.
  assign raw_o = (act_q < FW'(PEAK)) && (FW'(cnt_i) >= act_q);
endmodule

// File: rtl/pwm_dead_band.sv
module pwm_dead_band #(
  parameter int DEAD = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic hi_o,
  output logic lo_o
);
  localparam int DW = (DEAD < 1) ? 1 : $clog2(DEAD + 1);

  generate
    if (DEAD == 0) begin : g_nodead
      always_ff @(posedge clk) begin
        if (rst) begin
          hi_o <= 1'b0;
          lo_o <= 1'b0;
        end else begin
          hi_o <= raw_i;
          lo_o <= !raw_i;
        end
      end
    end else begin : g_dead
      logic          lvl_q;
      logic [DW-1:0] wait_q;
      logic [DW-1:0] idle_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          lvl_q  <= 1'b0;
          wait_q <= DW'(DEAD - 1);
          hi_o   <= 1'b0;
          lo_o   <= 1'b0;
        end else if (raw_i != lvl_q) begin
          lvl_q  <= raw_i;
          wait_q <= DW'(DEAD - 1);
          hi_o   <= 1'b0;
          lo_o   <= 1'b0;
        end else if (wait_q != '0) begin
          wait_q <= wait_q - DW'(1);
          hi_o   <= 1'b0;
          lo_o   <= 1'b0;
        end else begin
          hi_o <= lvl_q;
          lo_o <= !lvl_q;
        end
      end

      // Checker: consecutive cycles with both gates off, saturating.
      always_ff @(posedge clk) begin
        if (rst)                  idle_q <= '0;
        else if (hi_o || lo_o)    idle_q <= '0;
        else if (idle_q < DW'(DEAD)) idle_q <= idle_q + DW'(1);
      end

      // R6: a gate only turns on after the full dead interval
      p_dead_gap_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(hi_o) || $rose(lo_o)) |-> (idle_q >= DW'(DEAD)));
    end
  endgenerate

  // R7: complementary gates never overlap
  p_no_overlap_r7: assert property (@(posedge clk) disable iff (rst)
    !(hi_o && lo_o));
endmodule

// File: rtl/pwm_gate_gen.sv
module pwm_gate_gen
  import pwm_gate_pkg::*;
#(
  parameter int CARRIER_PEAK = 2000,
  parameter int DEAD_CLKS    = 100,
  parameter int FT_W         = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [FT_W-1:0]       ft_u,
  input  logic [FT_W-1:0]       ft_v,
  input  logic [FT_W-1:0]       ft_w,
  output logic [NUM_PHASES-1:0] gate_hi,
  output logic [NUM_PHASES-1:0] gate_lo,
  output logic                  sample_stb
);
  localparam int CNT_W = $clog2(CARRIER_PEAK + 1);

  logic [CNT_W-1:0] carrier;
  logic             load;
  logic [FT_W-1:0]  ft_arr [NUM_PHASES];
  logic [NUM_PHASES-1:0] demand;

  assign ft_arr[0] = ft_u;
  assign ft_arr[1] = ft_v;
  assign ft_arr[2] = ft_w;

  pwm_carrier #(.PEAK(CARRIER_PEAK), .CW(CNT_W)) i_carrier (
    .clk    (clk),
    .rst    (rst),
    .cnt_o  (carrier),
    .load_o (load),
    .stb_o  (sample_stb)
  );

  generate
    for (genvar g = 0; g < NUM_PHASES; g++) begin : g_phase
      pwm_phase_cmp #(.PEAK(CARRIER_PEAK), .CW(CNT_W), .FW(FT_W)) i_cmp (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .cnt_i  (carrier),
        .ft_i   (ft_arr[g]),
        .raw_o  (demand[g])
      );
      pwm_dead_band #(.DEAD(DEAD_CLKS)) i_dead (
        .clk   (clk),
        .rst   (rst),
        .raw_i (demand[g]),
        .hi_o  (gate_hi[g]),
        .lo_o  (gate_lo[g])
      );
    end
  endgenerate
endmodule

// File: tb/test_pwm_gate_gen.sv
module test_pwm_gate_gen;
  localparam int CLK_PERIOD = 20;
  localparam int PEAK = 2000;
  localparam int DEAD = 100;
  localparam int PER  = 2 * PEAK;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] ft_u = '0, ft_v = '0, ft_w = '0;
  logic [2:0]  gate_hi, gate_lo;
  logic        sample_stb;

  int tests = 0;
  int failed = 0;
  int stb_count = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_gate_gen #(.CARRIER_PEAK(PEAK), .DEAD_CLKS(DEAD), .FT_W(12)) i_pwm_gate_gen (
    .clk(clk), .rst(rst), .ft_u(ft_u), .ft_v(ft_v), .ft_w(ft_w),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .sample_stb(sample_stb)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input int u, input int v, input int w);
    ft_u = 12'(u); ft_v = 12'(v); ft_w = 12'(w);
  endtask

  task automatic wait_strobe();
    do @(negedge clk); while (!sample_stb);
    stb_count++;
  endtask

  // odd strobe index = peak, even = valley
  task automatic wait_kind(input bit want_peak);
    do wait_strobe(); while (((stb_count % 2) == 1) != want_peak);
  endtask

  task automatic expect_counts(input int a, input int b, output int h, output int l);
    int run;
    if (a >= PEAK && b >= PEAK) begin h = 0; l = PER; end
    else if (a == 0 && b == 0) begin h = PER; l = 0; end
    else begin
      run = PER + 1 - a - b;
      h = (run > DEAD) ? run - DEAD : 0;
      l = a + b - 1 - DEAD;
    end
  endtask

  task automatic run_case(input string req, input int au, input int bu, input int av,
                          input int bv, input int aw, input int bw, input bit glitch);
    int a[3], b[3];
    int hi_n[3], lo_n[3], both_n[3], ovl_n[3], rise_n[3];
    int stb_bad, eh, el;
    logic [2:0] prev_hi;
    a = '{au, av, aw};
    b = '{bu, bv, bw};
    for (int p = 0; p < 3; p++) begin
      hi_n[p] = 0; lo_n[p] = 0; both_n[p] = 0; ovl_n[p] = 0; rise_n[p] = 0;
    end
    stb_bad = 0;
    wait_kind(1'b1); drive(au, av, aw);
    wait_kind(1'b0); drive(bu, bv, bw);
    wait_kind(1'b1); drive(au, av, aw);
    wait_kind(1'b0);
    prev_hi = gate_hi;
    for (int i = 0; i < PER; i++) begin
      if (i > 0) @(negedge clk);
      for (int p = 0; p < 3; p++) begin
        if (gate_hi[p]) hi_n[p]++;
        if (gate_lo[p]) lo_n[p]++;
        if (!gate_hi[p] && !gate_lo[p]) both_n[p]++;
        if (gate_hi[p] && gate_lo[p]) ovl_n[p]++;
        if (i > 0 && gate_hi[p] && !prev_hi[p]) rise_n[p]++;
      end
      prev_hi = gate_hi;
      if (sample_stb != ((i == 0) || (i == PEAK))) stb_bad++;
      if (i == PEAK && sample_stb) stb_count++;
      if (i == 0) drive(bu, bv, bw);
      if (glitch && i == 1000) drive(0, 0, 0);
      if (glitch && i == 1500) drive(bu, bv, bw);
      if (i == PEAK) drive(au, av, aw);
    end
    check("R2", {req, " strobe placement"}, stb_bad, 0);
    for (int p = 0; p < 3; p++) begin
      expect_counts(a[p], b[p], eh, el);
      check(req, $sformatf("phase %0d high-side on clocks", p), hi_n[p], eh);
      check(req, $sformatf("phase %0d low-side on clocks", p), lo_n[p], el);
      check("R6", $sformatf("%s phase %0d both-off clocks", req, p), both_n[p], PER - eh - el);
      check("R7", $sformatf("%s phase %0d overlap clocks", req, p), ovl_n[p], 0);
      check(req, $sformatf("phase %0d high-side pulses", p), rise_n[p],
            (eh > 0 && eh < PER) ? 1 : 0);
    end
  endtask

  task automatic t_reset();
    int n, lo_at;
    rst = 1'b1;
    repeat (5) @(negedge clk);
    check("R9", "gates during reset", {29'd0, gate_hi} + {29'd0, gate_lo}, 0);
    check("R9", "strobe during reset", int'(sample_stb), 0);
    rst = 1'b0;
    n = 0; lo_at = -1;
    do begin
      @(negedge clk);
      n++;
      if (lo_at < 0 && gate_lo == 3'b111) lo_at = n;
      if (gate_hi != 3'b000) lo_at = -2;
    end while (!sample_stb && n < PER);
    stb_count = 1;
    check("R1", "clocks from reset release to first peak strobe", n, PEAK);
    check("R9", "low-side turn-on after reset", lo_at, DEAD);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    tests++; failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    t_reset();
    run_case("R4", 500, 500, 800, 800, 1000, 1000, 1'b0);
    run_case("R3", 300, 1200, 1200, 300, 700, 150, 1'b1);
    run_case("R5", 2000, 2000, 0, 0, 4095, 3000, 1'b0);
    run_case("R8", 1960, 1960, 1950, 1950, 1951, 1951, 1'b0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule